// File: doc/BRIEF.md
# Quad-I/O Serial Read Slave Engine

This block is the slave-side front end of a serial memory for the quad-lane fast-read transfer. A host lowers chip select, toggles the serial clock and sends a command byte on line 0. The engine then collects a 24-bit start address four bits per clock across all four data lines and takes a mode byte in the first two of six turnaround clocks. After that it streams bytes from a synchronous byte-wide memory array, one nibble per serial clock, and moves to the next address after every byte.

When the two nibbles of the mode byte are bitwise complements, the engine stays in a continuous-read state. The next transaction then leaves out the command byte and starts directly with the address. The read is refused if quad operation is disabled, or if a program, erase or status-write cycle is in progress. Any other command byte is ignored until chip select rises.

All logic runs on a fast system clock. Chip select, the serial clock and the data lines are brought in through a synchronizer and edge detector. Each serial clock half period must therefore last at least four system clock cycles.

Top module: `qspi_rd_slave`

## Requirements
- R1: After reset the output enables are 0, no array read is issued, the driven data nibble is 0, and continuous-read mode is off.
- R2: The command byte is sampled on line 0, MSB first, on rising serial clock edges. The code EBh starts a read only if quad_en_i is 1 and wip_i is 0 when its last bit is sampled. Otherwise the transaction has no output and no array read.
- R3: Any command code other than EBh is ignored until chip select goes high. No output is enabled and no array read is made.
- R4: The address is six nibbles, most significant first, sampled on rising edges, with bit 3 of each nibble on line 3. The first array read uses exactly this address.
- R5: Six turnaround clocks follow the address, and the first two of them carry the mode byte with the high nibble first. The first data nibble is valid from the falling edge that follows the sixth turnaround rising edge.
- R6: Each byte goes out high nibble first, with bit 3 on line 3. The output changes only on falling serial clock edges, and all four output enables are 1 during the data phase.
- R7: After each byte the address increases by one, and it wraps from FFFFFFh to 000000h. Each array read is a single-cycle request.
- R8: If mode byte bits [7:4] are the complement of bits [3:0], the next chip-select low skips the command, and the address follows at once. Such a transaction is refused, with continuous mode kept, if quad_en_i is 0 or wip_i is 1 when chip select falls.
- R9: Any non-complementary mode byte turns continuous mode off. The next transaction then needs the command byte again, and an address sent without it is ignored.
- R10: A chip-select rise during data output drops all output enables in the same instant and ends the read. A later transaction works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csn_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| sio_i | input | 4 | Data lines, input side |
| sio_o | output | 4 | Data lines, output side |
| sio_oe_o | output | 4 | Per-line output enables |
| quad_en_i | input | 1 | Quad operation enable flag |
| wip_i | input | 1 | Write cycle in progress flag |
| mem_addr_o | output | 24 | Array read address |
| mem_rd_o | output | 1 | Array read request, data on mem_rdata_i one cycle later |
| mem_rdata_i | input | 8 | Array read data |

## Verification
The hardest states to reach from the ports are the continuous-read transitions: a transaction that has no command byte and is refused because of a write in progress, and a following transaction that must still be treated as commandless. The stimulus first enters continuous mode with a complementary mode byte. It then makes a commandless read, raises wip_i at the next chip-select fall, and drops it again. A commandless read with a non-complementary byte follows, and after it comes a commandless address burst that must now be ignored. The address wrap is reached by starting two bytes below the top of the space.

// File: rtl/qspi_rd_pkg.sv
package qspi_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_TURN,
    ST_DATA,
    ST_SKIP
  } rd_state_e;

  localparam int unsigned NIB_W    = 4;
  localparam int unsigned CMD_BITS = 8;
endpackage

// File: rtl/qspi_rd_sync.sv
module qspi_rd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       csn_i,
  input  logic       sck_i,
  input  logic [3:0] sio_i,
  output logic       sck_rise_o,
  output logic       sck_fall_o,
  output logic       cs_act_o,
  output logic       cs_fall_o,
  output logic [3:0] sio_o
);
  localparam int unsigned W = 6;
  localparam logic [W-1:0] RST_V = 6'b10_0000;  // {csn, sck, sio}

  logic [W-1:0] pipe_q [STAGES];
  logic         sck_prev_q, csn_prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[g] <= RST_V;
        else         pipe_q[g] <= {csn_i, sck_i, sio_i};
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[g] <= RST_V;
        else         pipe_q[g] <= pipe_q[g-1];
    end
  end

  logic csn_s, sck_s;
  assign csn_s = pipe_q[STAGES-1][5];
  assign sck_s = pipe_q[STAGES-1][4];
  assign sio_o = pipe_q[STAGES-1][3:0];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sck_prev_q <= 1'b0;
      csn_prev_q <= 1'b1;
    end else begin
      sck_prev_q <= sck_s;
      csn_prev_q <= csn_s;
    end

  assign sck_rise_o = sck_s & ~sck_prev_q;
  assign sck_fall_o = ~sck_s & sck_prev_q;
  assign cs_act_o   = ~csn_s;
  assign cs_fall_o  = csn_prev_q & ~csn_s;
endmodule

// File: rtl/qspi_rd_fsm.sv
module qspi_rd_fsm
  import qspi_rd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned TURN_CYC = 6,
  parameter logic [7:0]  CMD_CODE = 8'hEB
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_rise_i,
  input  logic       cs_act_i,
  input  logic       cs_fall_i,
  input  logic [3:0] nib_i,
  input  logic       quad_en_i,
  input  logic       wip_i,
  output rd_state_e  state_o,
  output logic       addr_shift_o,
  output logic       addr_done_o,
  output logic       cont_o
);
  localparam int unsigned ADDR_NIB = ADDR_W / NIB_W;
  localparam int unsigned CNT_W    = $clog2(ADDR_NIB + TURN_CYC + CMD_BITS);

  rd_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [6:0]       cmd_q;
  logic [3:0]       mode_hi_q;
  logic             cont_q;
  logic [7:0]       cmd_full;
  logic             last_cmd, last_addr, last_turn, allow;

  assign cmd_full  = {cmd_q, nib_i[0]};
  assign last_cmd  = cnt_q == CNT_W'(CMD_BITS - 1);
  assign last_addr = cnt_q == CNT_W'(ADDR_NIB - 1);
  assign last_turn = cnt_q == CNT_W'(TURN_CYC - 1);
  assign allow     = quad_en_i & ~wip_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      cmd_q     <= '0;
      mode_hi_q <= '0;
      cont_q    <= 1'b0;
    end else if (!cs_act_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cs_fall_i) begin
          cnt_q <= '0;
          if (!cont_q)    state_q <= ST_CMD;
          else if (allow) state_q <= ST_ADDR;
          else            state_q <= ST_SKIP;
        end
        ST_CMD: if (sck_rise_i) begin
          cmd_q <= cmd_full[6:0];
          cnt_q <= cnt_q + 1'b1;
          if (last_cmd) begin
            cnt_q   <= '0;
            state_q <= (cmd_full == CMD_CODE && allow) ? ST_ADDR : ST_SKIP;
          end
        end
        ST_ADDR: if (sck_rise_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (last_addr) begin
            cnt_q   <= '0;
            state_q <= ST_TURN;
          end
        end
        ST_TURN: if (sck_rise_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(0)) mode_hi_q <= nib_i;
          if (cnt_q == CNT_W'(1)) cont_q <= (mode_hi_q == ~nib_i);
          if (last_turn) begin
            cnt_q   <= '0;
            state_q <= ST_DATA;
          end
        end
        default: ;
      endcase
    end

  assign state_o      = state_q;
  assign addr_shift_o = (state_q == ST_ADDR) & sck_rise_i & cs_act_i;
  assign addr_done_o  = addr_shift_o & last_addr;
  assign cont_o       = cont_q;
endmodule

// File: rtl/qspi_rd_dpath.sv
module qspi_rd_dpath
  import qspi_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              addr_shift_i,
  input  logic              addr_done_i,
  input  logic              data_fall_i,
  input  logic [3:0]        nib_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [7:0]        mem_rdata_i,
  output logic [3:0]        sio_o,
  output logic              oe_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              fetch_q, fetch_d_q, hi_q, oe_q;
  logic [7:0]        byte_q;
  logic [3:0]        sio_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      addr_q    <= '0;
      fetch_q   <= 1'b0;
      fetch_d_q <= 1'b0;
      hi_q      <= 1'b1;
      oe_q      <= 1'b0;
      byte_q    <= '0;
      sio_q     <= '0;
    end else begin
      fetch_q   <= 1'b0;
      fetch_d_q <= fetch_q;
      if (fetch_d_q) byte_q <= mem_rdata_i;
      if (addr_shift_i) addr_q <= {addr_q[ADDR_W-NIB_W-1:0], nib_i};
      if (addr_done_i) begin
        fetch_q <= 1'b1;
        hi_q    <= 1'b1;
      end
      if (data_fall_i) begin
        oe_q <= 1'b1;
        hi_q <= ~hi_q;
        if (hi_q) sio_q <= byte_q[7:4];
        else begin
          sio_q   <= byte_q[3:0];
          addr_q  <= addr_q + ADDR_W'(1);  // natural wrap at top
          fetch_q <= 1'b1;
        end
      end
      if (!cs_act_i) oe_q <= 1'b0;
    end

  assign mem_addr_o = addr_q;
  assign mem_rd_o   = fetch_q;
  assign sio_o      = sio_q;
  assign oe_o       = oe_q;
endmodule

// File: rtl/qspi_rd_slave.sv
module qspi_rd_slave
  import qspi_rd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TURN_CYC    = 6,
  parameter logic [7:0]  CMD_CODE    = 8'hEB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              sck_i,
  input  logic [3:0]        sio_i,
  output logic [3:0]        sio_o,
  output logic [3:0]        sio_oe_o,
  input  logic              quad_en_i,
  input  logic              wip_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [7:0]        mem_rdata_i
);
  logic       sck_rise, sck_fall, cs_act, cs_fall;
  logic [3:0] sio_s;
  rd_state_e  state;
  logic       addr_shift, addr_done, cont, oe, data_fall;

  qspi_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .csn_i, .sck_i, .sio_i,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall),
    .cs_act_o(cs_act), .cs_fall_o(cs_fall), .sio_o(sio_s)
  );

  qspi_rd_fsm #(.ADDR_W(ADDR_W), .TURN_CYC(TURN_CYC), .CMD_CODE(CMD_CODE)) u_fsm (
    .clk_i, .rst_ni,
    .sck_rise_i(sck_rise), .cs_act_i(cs_act), .cs_fall_i(cs_fall),
    .nib_i(sio_s), .quad_en_i, .wip_i,
    .state_o(state), .addr_shift_o(addr_shift), .addr_done_o(addr_done),
    .cont_o(cont)
  );

  assign data_fall = sck_fall & cs_act & (state == ST_DATA);

  qspi_rd_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk_i, .rst_ni, .cs_act_i(cs_act),
    .addr_shift_i(addr_shift), .addr_done_i(addr_done),
    .data_fall_i(data_fall), .nib_i(sio_s),
    .mem_addr_o, .mem_rd_o, .mem_rdata_i,
    .sio_o, .oe_o(oe)
  );

  // raw chip select gates the drivers so release needs no sync latency
  assign sio_oe_o = {4{oe & ~csn_i}};
endmodule

// File: rtl/qspi_rd_sva.sv
module qspi_rd_sva
  import qspi_rd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       quad_en_i,
  input logic       wip_i,
  input logic [3:0] sio_o,
  input logic [3:0] sio_oe_o,
  input logic       mem_rd_o,
  input rd_state_e  state,
  input logic       cont,
  input logic       sck_fall
);
  p_accept_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_ADDR && $past(state) == ST_CMD) |-> $past(quad_en_i && !wip_i));

  p_out_on_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sck_fall |=> $stable(sio_o));

  p_oe_data_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sio_oe_o) |-> state == ST_DATA);

  p_rd_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  p_cont_from_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cont != $past(cont)) |-> $past(state) == ST_TURN);
endmodule

bind qspi_rd_slave qspi_rd_sva u_sva (
  .clk_i, .rst_ni, .quad_en_i, .wip_i, .sio_o, .sio_oe_o, .mem_rd_o,
  .state, .cont, .sck_fall
);

// File: tb/qspi_rd_slave_tb_top.sv
module qspi_rd_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam logic [7:0] RD = 8'hEB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csn = 1'b1, sck = 1'b0;
  logic [3:0]  sio_drv = '0;
  logic [3:0]  sio_out, sio_oe;
  logic        qe = 1'b1, wip = 1'b0;
  logic [23:0] maddr;
  logic        mrd;
  logic [7:0]  mdata = '0;
  int          n_chk = 0, n_bad = 0, rd_cnt = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qspi_rd_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .csn_i(csn), .sck_i(sck), .sio_i(sio_drv),
    .sio_o(sio_out), .sio_oe_o(sio_oe), .quad_en_i(qe), .wip_i(wip),
    .mem_addr_o(maddr), .mem_rd_o(mrd), .mem_rdata_i(mdata)
  );

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (mrd) begin
      mdata <= pat(maddr);
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cyc(input logic [3:0] nib);
    @(negedge clk);
    sio_drv = nib;
    waitc(HALF);
    sck = 1'b1;
    waitc(HALF);
    sck = 1'b0;
  endtask

  // one transaction; abort raises chip select after the first data nibble
  task automatic xfer(input bit send_cmd, input logic [7:0] cmd, input logic [23:0] a,
                      input logic [7:0] p, input int nbytes, input bit ok,
                      input bit abort, input string req);
    int rd0;
    rd0 = rd_cnt;
    @(negedge clk);
    csn = 1'b0;
    waitc(4);
    if (send_cmd)
      for (int i = 7; i >= 0; i--) cyc({3'b000, cmd[i]});
    for (int i = 5; i >= 0; i--) cyc(a[i*4 +: 4]);
    cyc(p[7:4]);
    cyc(p[3:0]);
    for (int i = 0; i < 4; i++) cyc(4'h0);
    for (int b = 0; b < nbytes; b++) begin
      logic [7:0] e;
      e = pat(a + 24'(b));
      for (int h = 0; h < 2; h++) begin
        waitc(HALF);
        if (ok) begin
          chk({4'h0, sio_oe}, 8'h0F, {req, " oe"});
          chk({4'h0, sio_out}, {4'h0, (h == 0) ? e[7:4] : e[3:0]}, {req, " data"});
        end else begin
          chk({4'h0, sio_oe}, 8'h00, {req, " ignored oe"});
        end
        if (abort) begin
          csn = 1'b1;
          #1;
          chk({4'h0, sio_oe}, 8'h00, "R10 oe drop on cs rise");
          waitc(10);
          return;
        end
        sck = 1'b1;
        waitc(HALF);
        sck = 1'b0;
      end
    end
    waitc(HALF);
    csn = 1'b1;
    #1;
    chk({4'h0, sio_oe}, 8'h00, {req, " oe after cs"});
    waitc(10);
    if (!ok) chk(8'(rd_cnt - rd0), 8'h00, {req, " no array read"});
  endtask

  task automatic t_reset;
    chk({4'h0, sio_oe}, 8'h00, "R1 oe");
    chk({7'h0, mrd}, 8'h00, "R1 rd");
    chk({4'h0, sio_out}, 8'h00, "R1 sio");
    // continuous mode off: commandless burst is ignored
    xfer(1'b0, 8'h00, 24'h112233, 8'h00, 1, 1'b0, 1'b0, "R1 no cont");
  endtask

  task automatic t_plain;
    xfer(1'b1, RD, 24'h123456, 8'hFF, 4, 1'b1, 1'b0, "R4 R5 R6 plain");
  endtask

  task automatic t_wrap;
    xfer(1'b1, RD, 24'hFFFFFE, 8'h00, 4, 1'b1, 1'b0, "R7 wrap");
  endtask

  task automatic t_reject;
    wip = 1'b1;
    xfer(1'b1, RD, 24'h000010, 8'hFF, 1, 1'b0, 1'b0, "R2 wip");
    wip = 1'b0;
    qe = 1'b0;
    xfer(1'b1, RD, 24'h000010, 8'hFF, 1, 1'b0, 1'b0, "R2 qe off");
    qe = 1'b1;
    xfer(1'b1, 8'h03, 24'h000010, 8'hFF, 1, 1'b0, 1'b0, "R3 other cmd");
  endtask

  task automatic t_cont;
    xfer(1'b1, RD, 24'h000100, 8'hA5, 2, 1'b1, 1'b0, "R8 enter");
    xfer(1'b0, 8'h00, 24'h0ABCDE, 8'h5A, 2, 1'b1, 1'b0, "R8 skip cmd");
    wip = 1'b1;
    xfer(1'b0, 8'h00, 24'h000300, 8'hF0, 1, 1'b0, 1'b0, "R8 wip refuse");
    wip = 1'b0;
    xfer(1'b0, 8'h00, 24'h000200, 8'h00, 2, 1'b1, 1'b0, "R8 kept after refuse");
    xfer(1'b0, 8'h00, 24'h112233, 8'h00, 1, 1'b0, 1'b0, "R9 exit");
    xfer(1'b1, RD, 24'h00F00F, 8'h55, 2, 1'b1, 1'b0, "R9 cmd again");
  endtask

  task automatic t_abort;
    xfer(1'b1, RD, 24'h400000, 8'hFF, 3, 1'b1, 1'b1, "R10 abort");
    xfer(1'b1, RD, 24'h400080, 8'hFF, 2, 1'b1, 1'b0, "R10 after abort");
  endtask

  initial begin
    waitc(5);
    rst_n = 1'b1;
    waitc(5);
    t_reset();
    t_plain();
    t_wrap();
    t_reject();
    t_cont();
    t_abort();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule